// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps the time of day and the calendar date in binary-coded decimal: seconds, minutes, hours on a 24-hour scale, day of week, day of month, month and a two-digit year, plus a century flag. Time advances from a slow tick input. The tick is counted down to one-second steps by a small accumulator. A stop flag freezes counting. A century-enable flag lets the century flag flip each time the year wraps from 99 to 00.

A host reaches the eight bytes through a simple synchronous register port. Reads are combinational and writes take effect at the next clock edge. While the host raises its read-in-progress flag, the visible bytes are frozen. An internal shadow copy keeps counting, so no time is lost. The shadow is copied to the visible bytes in a single cycle when the flag drops, or when a pending update has waited a bounded number of clock cycles.

Byte layout by address: 0 seconds (bit 7 stop, bits 6:0 BCD); 1 minutes (bits 6:0); 2 hours (bit 7 century-enable, bit 6 century, bits 5:0 BCD); 3 day of week (bits 2:0, 1 to 7); 4 day of month (bits 5:0); 5 month (bits 4:0); 6 year (bits 7:0); 7 a plain 8-bit control byte that is stored and read back.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the bytes read, for addresses 0 to 7: 00, 00, 00, 01, 01, 01, 00, 00.
- R2: Seconds advance by one BCD step on the TICKS_PER_SEC-th tick that is counted, and the new value is readable after the clock edge that samples that tick.
- R3: Counting carries in cascade. Seconds 59 goes to 00 and carries into minutes, minutes 59 into hours, and hours 23 into the next day. At that point day of week goes from 07 to 01, or otherwise steps by one.
- R4: The day of month wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other long months. February ends on 29 when the two-digit year is divisible by four (00 included) and on 28 otherwise.
- R5: Month 12 wraps to 01 and the year advances. Year 99 wraps to 00, and at that moment hours bit 6 inverts if hours bit 7 is 1 and is unchanged if bit 7 is 0.
- R6: While seconds bit 7 is 1, ticks are ignored and no byte changes. After it is cleared, counting resumes.
- R7: Bits outside the defined fields read as 0 after any write: minutes bit 7, day-of-week bits 7:3, day-of-month bits 7:6 and month bits 7:5.
- R8: While host_rd_active is high, the visible bytes do not change on ticks. The edge after it drops shows the full elapsed time.
- R9: A pending update held by host_rd_active is forced to the visible bytes exactly HOLD_CYCLES clock edges after the edge that created it.
- R10: A write to address 0 clears the tick accumulator. Writes to other addresses leave it untouched.
- R11: A host write is readable at the next cycle, even while host_rd_active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle timing pulse, TICKS_PER_SEC per second |
| host_rd_active | input | 1 | Host is reading the clock bytes; freeze visible bytes |
| host_wr_en | input | 1 | Write strobe for host_addr/host_wdata |
| host_addr | input | 3 | Byte address 0 to 7 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Visible byte at host_addr |

## Verification
The bench targets the month-end boundaries: 30-day months, February in a leap year, February in a common year, and year 00 treated as leap. A wrong day table would show 31 April or skip 29 February. It checks the century flag in both enable states across the 99-to-00 wrap, and a design that ignores the enable flips it anyway. It measures the read hold to the exact edge. A design that drops ticks during the hold shows fewer seconds when the flag falls, and one with an off-by-one counter releases a cycle early or late. It also checks that a seconds write restarts the sub-second phase while other writes do not, which exposes an accumulator cleared on every write.

// File: rtl/rtc_cal_pkg.sv
// Package: calendar state type, BCD helpers, byte packing for the host port.
// Assumes all stored values are BCD; no range checking on host writes.
package rtc_cal_pkg;

    typedef struct packed {
        logic       st;
        logic [6:0] sec;
        logic [6:0] min;
        logic       ceb;
        logic       cb;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } cal_t;

    localparam cal_t CAL_RESET = '{st: 1'b0, sec: 7'h00, min: 7'h00, ceb: 1'b0,
                                   cb: 1'b0, hr: 6'h00, dow: 3'd1, date: 6'h01,
                                   mon: 5'h01, yr: 8'h00};

    // One BCD step on a two-digit value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap when the two-digit year is a multiple of four.
    function automatic logic is_leap(input logic [7:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    // Last day of the month in BCD.
    function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // Apply one host write to a calendar image; unused bits are dropped.
    function automatic cal_t apply_wr(input cal_t c, input logic [2:0] a, input logic [7:0] d);
        cal_t r;
        r = c;
        case (a)
            3'd0: begin r.st = d[7]; r.sec = d[6:0]; end
            3'd1: r.min = d[6:0];
            3'd2: begin r.ceb = d[7]; r.cb = d[6]; r.hr = d[5:0]; end
            3'd3: r.dow = d[2:0];
            3'd4: r.date = d[5:0];
            3'd5: r.mon = d[4:0];
            3'd6: r.yr = d;
            default: ;
        endcase
        return r;
    endfunction

    // Pack one byte of the calendar for the host read port.
    function automatic logic [7:0] rd_byte(input cal_t c, input logic [7:0] ctl, input logic [2:0] a);
        case (a)
            3'd0:    return {c.st, c.sec};
            3'd1:    return {1'b0, c.min};
            3'd2:    return {c.ceb, c.cb, c.hr};
            3'd3:    return {5'd0, c.dow};
            3'd4:    return {2'd0, c.date};
            3'd5:    return {3'd0, c.mon};
            3'd6:    return c.yr;
            default: return ctl;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
// Module: rtc_tick_gate
// Counts tick pulses into one-second strobes. Assumes tick_in is a
// single-cycle pulse. Counting pauses while run is low; clr restarts the phase.
module rtc_tick_gate #(
    parameter int TICKS_PER_SEC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic run,
    input  logic clr,
    output logic sec_pulse
);
    localparam int ACC_W = $clog2(TICKS_PER_SEC + 1);
    localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(TICKS_PER_SEC - 1);

    logic [ACC_W-1:0] acc;

    assign sec_pulse = tick_in && run && (acc == ACC_TOP) && !clr;

    // Sub-second accumulator: clear on seconds write, step on counted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                acc <= '0;
        else if (clr)              acc <= '0;
        else if (tick_in && run)   acc <= (acc == ACC_TOP) ? '0 : acc + 1'b1;
    end

    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_TOP);
    p_clear_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    p_frozen_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(acc));
endmodule

// File: rtl/rtc_cal_advance.sv
// Module: rtc_cal_advance
// Combinational one-second step of the calendar with BCD carries, month
// lengths, leap years and the gated century flip. Assumes BCD inputs.
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic [7:0] s_inc, m_inc, h_inc, d_inc, mo_inc, y_inc;

    // Cascade the carries from seconds up to the century flag.
    always_comb begin
        s_inc  = bcd_inc({1'b0, cur.sec});
        m_inc  = bcd_inc({1'b0, cur.min});
        h_inc  = bcd_inc({2'b0, cur.hr});
        d_inc  = bcd_inc({2'b0, cur.date});
        mo_inc = bcd_inc({3'b0, cur.mon});
        y_inc  = bcd_inc(cur.yr);
        nxt    = cur;
        if (cur.sec != 7'h59) nxt.sec = s_inc[6:0];
        else begin
            nxt.sec = 7'h00;
            if (cur.min != 7'h59) nxt.min = m_inc[6:0];
            else begin
                nxt.min = 7'h00;
                if (cur.hr != 6'h23) nxt.hr = h_inc[5:0];
                else begin
                    nxt.hr  = 6'h00;
                    nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.date != last_day(cur.mon, cur.yr)) nxt.date = d_inc[5:0];
                    else begin
                        nxt.date = 6'h01;
                        if (cur.mon != 5'h12) nxt.mon = mo_inc[4:0];
                        else begin
                            nxt.mon = 5'h01;
                            if (cur.yr != 8'h99) nxt.yr = y_inc;
                            else begin
                                nxt.yr = 8'h00;
                                nxt.cb = cur.cb ^ cur.ceb;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_read_hold.sv
// Module: rtc_read_hold
// Decides when visible registers follow the shadow. While the host reads,
// an update is held as pending and forced after HOLD_CYCLES edges.
module rtc_read_hold #(
    parameter int HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_active,
    input  logic advance,
    output logic copy_en,
    output logic force_rel
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYCLES - 1);

    logic          pend;
    logic [CW-1:0] cnt;

    assign force_rel = pend && rd_active && (cnt == CNT_LAST);
    assign copy_en   = !rd_active || force_rel;

    // Pending flag and age counter for a held update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else begin
            pend <= rd_active && !force_rel && (pend || advance);
            cnt  <= (pend && !force_rel) ? cnt + 1'b1 : '0;
        end
    end

    p_hold_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt <= CNT_LAST));
    p_pend_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> !pend);
endmodule

// File: rtl/rtc_calendar_core.sv
// Module: rtc_calendar_core (top)
// BCD calendar with shadow and visible copies. Shadow always holds true
// time; visible copy follows it except while the host reads. Host writes
// go to both copies. Address 7 is a plain stored control byte.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1,
    parameter int HOLD_CYCLES   = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       host_rd_active,
    input  logic       host_wr_en,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    cal_t       sh, vis, sh_adv, sh_next, vis_next, adv_out;
    logic [7:0] ctl;
    logic       sec_pulse, copy_en, force_rel, clr_acc;

    assign clr_acc = host_wr_en && (host_addr == 3'd0);

    rtc_tick_gate #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_gate (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .run(!sh.st),
        .clr(clr_acc), .sec_pulse(sec_pulse)
    );

    rtc_cal_advance u_adv (.cur(sh), .nxt(adv_out));

    rtc_read_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .rd_active(host_rd_active),
        .advance(sec_pulse), .copy_en(copy_en), .force_rel(force_rel)
    );

    // Next shadow and visible images, host write taking priority per byte.
    always_comb begin
        sh_adv   = sec_pulse ? adv_out : sh;
        sh_next  = host_wr_en ? apply_wr(sh_adv, host_addr, host_wdata) : sh_adv;
        vis_next = copy_en ? sh_next
                 : (host_wr_en ? apply_wr(vis, host_addr, host_wdata) : vis);
    end

    // Calendar state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= CAL_RESET;
            vis <= CAL_RESET;
            ctl <= 8'h00;
        end else begin
            sh  <= sh_next;
            vis <= vis_next;
            if (host_wr_en && host_addr == 3'd7) ctl <= host_wdata;
        end
    end

    assign host_rdata = rd_byte(vis, ctl, host_addr);

    p_stop_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sh.st && !host_wr_en) |=> $stable(sh));
    p_century_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh.ceb && !host_wr_en) |=> $stable(sh.cb));
    p_vis_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_active && !host_wr_en && !force_rel) |=> $stable(vis));
    p_wr_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_addr == 3'd1) |=> (vis.min == $past(host_wdata[6:0])));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
    localparam int TPS  = 4;
    localparam int HOLD = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       host_rd_active = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS), .HOLD_CYCLES(HOLD)) i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .host_rd_active(host_rd_active),
        .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic t_reset;
        rd_chk("R1 sec", 3'd0, 8'h00); rd_chk("R1 min", 3'd1, 8'h00);
        rd_chk("R1 hr", 3'd2, 8'h00);  rd_chk("R1 dow", 3'd3, 8'h01);
        rd_chk("R1 date", 3'd4, 8'h01); rd_chk("R1 mon", 3'd5, 8'h01);
        rd_chk("R1 yr", 3'd6, 8'h00);  rd_chk("R1 ctl", 3'd7, 8'h00);
    endtask

    task automatic t_seconds;
        wr(3'd0, 8'h10);
        ticks(TPS - 1); rd_chk("R2 before last tick", 3'd0, 8'h10);
        ticks(1);       rd_chk("R2 one second", 3'd0, 8'h11);
        wr(3'd7, 8'hA5); rd_chk("R11 control byte", 3'd7, 8'hA5);
    endtask

    task automatic t_accum;
        wr(3'd0, 8'h20); ticks(2);
        wr(3'd1, 8'h05); ticks(2);
        rd_chk("R10 minute write keeps phase", 3'd0, 8'h21);
        ticks(2); wr(3'd0, 8'h30); ticks(2);
        rd_chk("R10 seconds write clears phase", 3'd0, 8'h30);
        ticks(2); rd_chk("R10 after full phase", 3'd0, 8'h31);
    endtask

    task automatic t_cascade;
        wr(3'd3, 8'h07);
        set_time(8'h23, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59);
        ticks(TPS);
        rd_chk("R3 sec wrap", 3'd0, 8'h00); rd_chk("R3 min wrap", 3'd1, 8'h00);
        rd_chk("R3 hr wrap", 3'd2, 8'h00);  rd_chk("R3 dow 7->1", 3'd3, 8'h01);
        rd_chk("R3 date step", 3'd4, 8'h16);
    endtask

    task automatic t_months;
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 apr30 date", 3'd4, 8'h01); rd_chk("R4 apr30 mon", 3'd5, 8'h05);
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 feb28 common", 3'd4, 8'h01); rd_chk("R4 feb28 common mon", 3'd5, 8'h03);
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 feb28 leap", 3'd4, 8'h29);
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 feb29 leap", 3'd4, 8'h01);
        set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 year00 leap", 3'd4, 8'h29);
        set_time(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R4 jan30", 3'd4, 8'h31);
    endtask

    task automatic t_century;
        set_time(8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R5 year wrap", 3'd6, 8'h00); rd_chk("R5 month wrap", 3'd5, 8'h01);
        rd_chk("R5 century flips", 3'd2, 8'hC0);
        set_time(8'h99, 8'h12, 8'h31, 8'h63, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R5 century kept", 3'd2, 8'h40);
        set_time(8'h41, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59); ticks(TPS);
        rd_chk("R5 year step", 3'd6, 8'h42); rd_chk("R5 no flip mid", 3'd2, 8'h80);
    endtask

    task automatic t_stop;
        wr(3'd0, 8'h85); ticks(2 * TPS);
        rd_chk("R6 stopped", 3'd0, 8'h85);
        wr(3'd0, 8'h05); ticks(TPS);
        rd_chk("R6 resumed", 3'd0, 8'h06);
    endtask

    task automatic t_unused;
        wr(3'd1, 8'hA5); rd_chk("R7 min", 3'd1, 8'h25);
        wr(3'd3, 8'hFD); rd_chk("R7 dow", 3'd3, 8'h05);
        wr(3'd4, 8'hF1); rd_chk("R7 date", 3'd4, 8'h31);
        wr(3'd5, 8'hF2); rd_chk("R7 mon", 3'd5, 8'h12);
    endtask

    task automatic t_hold;
        wr(3'd1, 8'h10); wr(3'd0, 8'h40);
        @(negedge clk); host_rd_active = 1'b1;
        ticks(3 * TPS);
        rd_chk("R8 frozen", 3'd0, 8'h40);
        @(negedge clk); host_rd_active = 1'b0;
        rd_chk("R8 caught up", 3'd0, 8'h43);
    endtask

    task automatic t_bound;
        wr(3'd0, 8'h50);
        @(negedge clk); host_rd_active = 1'b1;
        wr(3'd1, 8'h33); rd_chk("R11 write during hold", 3'd1, 8'h33);
        ticks(TPS);
        repeat (HOLD - 1) @(posedge clk);
        rd_chk("R9 still held", 3'd0, 8'h50);
        @(posedge clk);
        rd_chk("R9 forced", 3'd0, 8'h51);
        @(negedge clk); host_rd_active = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_seconds;
        t_accum;
        t_cascade;
        t_months;
        t_century;
        t_stop;
        t_unused;
        t_hold;
        t_bound;
        finish_run;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end
endmodule